// File: doc/BRIEF.md
# Selectable-Order Noise-Shaping Divide-Offset Modulator

This block drives the modulus control of a fractional-N feedback divider. On every comparison cycle it produces a small signed offset, and the divider adds that offset to its base integer ratio. Over a long run the offsets average to `num_i / den_i`, so the loop settles on a fractional multiple of the comparison frequency. The quantization error of that averaging is pushed toward high offset frequencies, where the loop filter removes it. The amount of shaping depends on the chosen order.

The modulator is a cascade of three first-order accumulator stages. Each stage adds its input to its stored residue, reduces the result by the denominator when it reaches it, and emits the reduction as a carry bit. Each later stage accumulates the new residue of the stage before it. The carries from the later stages are differenced once or twice and then summed with the first-stage carry. The order is chosen at run time:
- Order 1 is the plain accumulator.
- Orders 2 and 3 enable further stages.

An optional one-bit pseudo-random dither is added to the input of the last active stage. It breaks up periodic patterns without moving the mean. Any change to the order or dither setting restarts the modulator from a clean state.

Top module: `frac_sdm_mod`

## Requirements
- R1: `valid_o` is high in exactly the cycle after a cycle in which `step_i` was high and the configuration did not change; `offset_o` takes its new value in that same cycle and keeps it otherwise.
- R2: With `order_i` equal to 0 or 1, only stage 1 runs: `s = acc1 + num_i`; if `s >= den_i`, then `s -= den_i` and the carry c1 is 1. `acc1` takes `s`, and `offset_o = c1`, so only 0 and +1 occur.
- R3: With `order_i = 2` and dither off, stage 2 accumulates the new stage-1 residue in the same way, giving carry c2. Then `offset_o = c1 + c2 - c2'`, where c2' is the c2 of the previous step. Values stay within -1..+2.
- R4: With `order_i = 3` and dither off, stage 3 accumulates the new stage-2 residue, giving carry c3. Then `offset_o = c1 + c2 - c2' + c3 - 2*c3' + c3''`, where primes mark earlier steps. Values stay within -3..+4.
- R5: For any order and either dither setting, the sum S of N offsets taken from a clean start satisfies `|den_i*S - N*num_i| <= 3*den_i` (precondition: `num_i < den_i`).
- R6: With dither on in order 2 or 3, a pseudo-random bit is added to the input of the last active stage. The sequence then differs from the undithered one, while the R3/R4 value ranges and the R5 mean still hold.
- R7: If `order_i` or `dither_en_i` differs from its value in the previous cycle, all of the following happen:
  - all accumulator, differencing and dither registers are cleared;
  - `offset_o` is cleared;
  - a `step_i` in that cycle is dropped and gives no `valid_o`.

  The sequence that follows equals one from reset.
- R8: During and after reset, `valid_o` is 0 and `offset_o` is 0.
- R9: In first-order operation `dither_en_i` has no effect on the offset sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Comparison-cycle strobe; advances the modulator once |
| num_i | input | ACC_W | Fractional numerator, must be below den_i |
| den_i | input | ACC_W | Fractional denominator (modulus), at least 1 |
| order_i | input | 2 | Order select: 0 or 1 first, 2 second, 3 third |
| dither_en_i | input | 1 | Enables pseudo-random dither in orders 2 and 3 |
| offset_o | output | 4 | Signed two's-complement offset added to the base divide ratio |
| valid_o | output | 1 | One-cycle strobe marking a new offset |

## Verification
The hardest case to reach from the ports is a configuration change that lands in the same cycle as a step strobe. Here the clear must win, the step must vanish, and the following sequence must start over exactly. The bench schedules the strobe and the order or dither change on the same edge. It then switches back and compares the restart against a freshly cleared arithmetic model. Dither can only be observed statistically. It is checked by running the same fraction with and without dither, which must differ at some step while keeping the ranges and the long-run mean. Every numerator is swept for several small denominators in all four order codes, which exercises long carry runs in the cascade.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

   // Width of the signed divide-ratio offset; holds -3..+4 for order 3.
   localparam int OFF_W = 4;

   typedef struct packed {
      logic [1:0] ord;
      logic       dith;
   } sdm_cfg_t;

   // Feedback tap masks for maximal-length Fibonacci shift registers.
   // Bit (n-1) set for each polynomial term x^n; zero marks an unsupported width.
   function automatic logic [31:0] lfsr_taps(input int w);
      case (w)
         7:       return 32'h0000_0060;
         9:       return 32'h0000_0110;
         10:      return 32'h0000_0240;
         11:      return 32'h0000_0500;
         15:      return 32'h0000_6000;
         17:      return 32'h0001_2000;
         20:      return 32'h0009_0000;
         23:      return 32'h0042_0000;
         31:      return 32'h4800_0000;
         default: return 32'h0000_0000;
      endcase
   endfunction

endpackage

// File: rtl/sdm_lfsr.sv
module sdm_lfsr #(
   parameter int             W    = 15,
   parameter logic [W-1:0]   SEED = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic adv,
   output logic bit_o
);
   localparam logic [31:0]  TAPS32 = sdm_pkg::lfsr_taps(W);
   localparam logic [W-1:0] TAPS   = TAPS32[W-1:0];

   generate
      if (TAPS32 == 32'h0) begin : g_bad_width
         $fatal(1, "sdm_lfsr: unsupported width %0d", W);
      end
      if (SEED == '0) begin : g_bad_seed
         $fatal(1, "sdm_lfsr: seed must be nonzero");
      end
   endgenerate

   logic [W-1:0] st_q;
   logic         fb;

   assign fb    = ^(st_q & TAPS);
   assign bit_o = st_q[W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      st_q <= SEED;
      else if (clr)    st_q <= SEED;
      else if (adv)    st_q <= {st_q[W-2:0], fb};
   end

endmodule

// File: rtl/sdm_acc_stage.sv
module sdm_acc_stage #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic [W-1:0] den_i,
   input  logic [W:0]   add_i,
   output logic         carry_o,
   output logic [W-1:0] res_o
);
   logic [W-1:0] acc_q;
   logic [W:0]   sum;
   logic [W:0]   den_x;

   // acc_q < den and add_i <= den, so one subtraction always suffices.
   assign den_x   = {1'b0, den_i};
   assign sum     = {1'b0, acc_q} + add_i;
   assign carry_o = (sum >= den_x);
   assign res_o   = carry_o ? W'(sum - den_x) : sum[W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc_q <= '0;
      else if (clr)    acc_q <= '0;
      else if (en)     acc_q <= res_o;
   end

endmodule

// File: rtl/sdm_noise_comb.sv
module sdm_noise_comb #(
   parameter int OW = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 adv,
   input  logic [1:0]           ord,
   input  logic [2:0]           carry,
   output logic signed [OW-1:0] off_o,
   output logic                 valid_o
);
   generate
      if (OW < 4) begin : g_bad_ow
         $fatal(1, "sdm_noise_comb: offset width %0d too narrow", OW);
      end
   endgenerate

   logic c1, c2, c3;
   logic c2_d1, c3_d1, c3_d2;
   logic signed [OW-1:0] t1, t2, t2p, t3, t3p, t3pp, y;

   assign c1 = carry[0];
   assign c2 = (ord >= 2'd2) ? carry[1] : 1'b0;
   assign c3 = (ord == 2'd3) ? carry[2] : 1'b0;

   always_comb begin
      t1   = OW'(c1);
      t2   = OW'(c2);
      t2p  = OW'(c2_d1);
      t3   = OW'(c3);
      t3p  = OW'(c3_d1);
      t3pp = OW'(c3_d2);
      // (1 - z^-1) on stage 2, (1 - z^-1)^2 on stage 3.
      y    = t1 + (t2 - t2p) + (t3 - (t3p <<< 1) + t3pp);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c2_d1   <= 1'b0;
         c3_d1   <= 1'b0;
         c3_d2   <= 1'b0;
         off_o   <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= adv;
         if (clr) begin
            c2_d1 <= 1'b0;
            c3_d1 <= 1'b0;
            c3_d2 <= 1'b0;
            off_o <= '0;
         end else if (adv) begin
            c2_d1 <= c2;
            c3_d1 <= c3;
            c3_d2 <= c3_d1;
            off_o <= y;
         end
      end
   end

endmodule

// File: rtl/frac_sdm_mod.sv
module frac_sdm_mod #(
   parameter int ACC_W  = 16,
   parameter int LFSR_W = 15
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              step_i,
   input  logic [ACC_W-1:0]                  num_i,
   input  logic [ACC_W-1:0]                  den_i,
   input  logic [1:0]                        order_i,
   input  logic                              dither_en_i,
   output logic signed [sdm_pkg::OFF_W-1:0]  offset_o,
   output logic                              valid_o
);
   import sdm_pkg::*;

   localparam int NSTG = 3;

   generate
      if (ACC_W < 2 || ACC_W > 30) begin : g_bad_accw
         $fatal(1, "frac_sdm_mod: ACC_W %0d out of range", ACC_W);
      end
   endgenerate

   sdm_cfg_t cfg_now, cfg_q;
   logic     clr, adv;
   logic [1:0] ord_eff;
   logic     lfsr_bit, inj_bit;

   logic [ACC_W:0]   stg_add [NSTG];
   logic [ACC_W-1:0] stg_res [NSTG];
   logic [NSTG-1:0]  stg_cy;

   assign cfg_now = '{ord: order_i, dith: dither_en_i};
   assign clr     = (cfg_now != cfg_q);
   assign adv     = step_i & ~clr;
   assign ord_eff = (order_i == 2'd0) ? 2'd1 : order_i;
   assign inj_bit = dither_en_i & lfsr_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= '{ord: 2'd1, dith: 1'b0};
      else        cfg_q <= cfg_now;
   end

   sdm_lfsr #(.W(LFSR_W)) u_dith (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .adv   (adv),
      .bit_o (lfsr_bit)
   );

   generate
      for (genvar k = 0; k < NSTG; k++) begin : g_stg
         if (k == 0) begin : g_first
            assign stg_add[k] = {1'b0, num_i};
         end else begin : g_next
            // Dither enters only the last active stage.
            assign stg_add[k] = {1'b0, stg_res[k-1]}
                              + (ACC_W+1)'(inj_bit && (ord_eff == 2'(k+1)));
         end
         sdm_acc_stage #(.W(ACC_W)) u_acc (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .en      (adv && (ord_eff > 2'(k))),
            .den_i   (den_i),
            .add_i   (stg_add[k]),
            .carry_o (stg_cy[k]),
            .res_o   (stg_res[k])
         );
      end
   endgenerate

   sdm_noise_comb #(.OW(OFF_W)) u_comb (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .adv     (adv),
      .ord     (ord_eff),
      .carry   (stg_cy),
      .off_o   (offset_o),
      .valid_o (valid_o)
   );

endmodule

// File: rtl/sdm_mod_chk.sv
module sdm_mod_chk (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             step_i,
   input logic [1:0]                       order_i,
   input logic                             dither_en_i,
   input logic signed [sdm_pkg::OFF_W-1:0] offset_o,
   input logic                             valid_o
);

   p_valid_after_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(step_i));

   p_order1_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && ($past(order_i) <= 2'd1)) |-> (offset_o == 4'sd0 || offset_o == 4'sd1));

   p_order2_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && ($past(order_i) == 2'd2)) |-> (offset_o >= -4'sd1 && offset_o <= 4'sd2));

   p_order3_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && ($past(order_i) == 2'd3)) |-> (offset_o >= -4'sd3 && offset_o <= 4'sd4));

   p_cfg_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ({order_i, dither_en_i} != $past({order_i, dither_en_i})) |=> !valid_o);

endmodule

bind frac_sdm_mod sdm_mod_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .step_i      (step_i),
   .order_i     (order_i),
   .dither_en_i (dither_en_i),
   .offset_o    (offset_o),
   .valid_o     (valid_o)
);

// File: tb/frac_sdm_mod_tb.sv
module frac_sdm_mod_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW         = 6;

   logic                 clk = 1'b0;
   logic                 rst_n;
   logic                 step_i;
   logic [AW-1:0]        num_i, den_i;
   logic [1:0]           order_i;
   logic                 dither_en_i;
   logic signed [3:0]    offset_o;
   logic                 valid_o;

   frac_sdm_mod #(.ACC_W(AW), .LFSR_W(15)) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .step_i      (step_i),
      .num_i       (num_i),
      .den_i       (den_i),
      .order_i     (order_i),
      .dither_en_i (dither_en_i),
      .offset_o    (offset_o),
      .valid_o     (valid_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 0;

   // Arithmetic model of the requirement equations (dither off).
   int m_a1, m_a2, m_a3, m_c2p, m_c3p, m_c3pp;

   function automatic void m_clear();
      m_a1 = 0; m_a2 = 0; m_a3 = 0; m_c2p = 0; m_c3p = 0; m_c3pp = 0;
   endfunction

   function automatic int m_step(int ord, int num, int den);
      int s, c1, c2, c3, y;
      c2 = 0; c3 = 0;
      s = m_a1 + num; c1 = (s >= den) ? 1 : 0; if (c1 == 1) s -= den; m_a1 = s;
      if (ord >= 2) begin
         s = m_a2 + m_a1; c2 = (s >= den) ? 1 : 0; if (c2 == 1) s -= den; m_a2 = s;
      end
      if (ord == 3) begin
         s = m_a3 + m_a2; c3 = (s >= den) ? 1 : 0; if (c3 == 1) s -= den; m_a3 = s;
      end
      if (ord <= 1)      y = c1;
      else if (ord == 2) y = c1 + c2 - m_c2p;
      else               y = c1 + c2 - m_c2p + c3 - 2*m_c3p + m_c3pp;
      m_c2p = c2; m_c3pp = m_c3p; m_c3p = c3;
      return y;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic apply_reset(input int ord, input bit dith, input int num, input int den);
      step_i = 1'b0; rst_n = 1'b0;
      order_i = 2'(ord); dither_en_i = dith; num_i = AW'(num); den_i = AW'(den);
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); @(negedge clk);
   endtask

   task automatic do_step(output int y, output bit v);
      @(negedge clk) step_i = 1'b1;
      @(negedge clk) step_i = 1'b0;
      y = int'(offset_o);
      v = valid_o;
   endtask

   function automatic string tag_of(int ord);
      if (ord <= 1)      return "R2";
      else if (ord == 2) return "R3";
      else               return "R4";
   endfunction

   function automatic bit mean_ok(int s, int n, int num, int den);
      int e;
      e = den*s - n*num;
      if (e < 0) e = -e;
      return (e <= 3*den);
   endfunction

   initial begin
      int dens[7] = '{1, 2, 3, 5, 7, 16, 63};
      int y, e, s, diffs;
      bit v;

      step_i = 1'b0; rst_n = 1'b0; order_i = 2'd1; dither_en_i = 1'b0;
      num_i = '0; den_i = AW'(1);
      @(negedge clk); @(negedge clk);
      // R8: reset state
      chk(valid_o == 1'b0, "R8 valid in reset", int'(valid_o), 0);
      chk(offset_o == 4'sd0, "R8 offset in reset", int'(offset_o), 0);
      rst_n = 1'b1;
      @(negedge clk); @(negedge clk);
      chk(valid_o == 1'b0, "R8 valid after reset", int'(valid_o), 0);
      chk(offset_o == 4'sd0, "R8 offset after reset", int'(offset_o), 0);

      // R2 R3 R4 R5 R1: exhaustive numerator sweep, dither off, all order codes.
      for (int ord = 0; ord < 4; ord++) begin
         foreach (dens[d]) begin
            for (int num = 0; num < dens[d]; num++) begin
               apply_reset(ord, 1'b0, num, dens[d]);
               m_clear();
               s = 0;
               for (int i = 0; i < 40; i++) begin
                  do_step(y, v);
                  e = m_step(ord, num, dens[d]);
                  chk(v == 1'b1, "R1 valid after step", int'(v), 1);
                  chk(y == e, tag_of(ord), y, e);
                  s += y;
               end
               chk(mean_ok(s, 40, num, dens[d]), "R5 mean", dens[d]*s, 40*num);
            end
         end
      end

      // R1: output holds and valid drops between steps.
      apply_reset(3, 1'b0, 5, 7);
      m_clear();
      do_step(y, v);
      e = m_step(3, 5, 7);
      chk(y == e, "R4", y, e);
      @(negedge clk);
      chk(valid_o == 1'b0, "R1 valid idle", int'(valid_o), 0);
      chk(int'(offset_o) == y, "R1 offset hold", int'(offset_o), y);

      // R9: dither has no effect in first order.
      for (int t = 0; t < 2; t++) begin
         int num, den;
         num = (t == 0) ? 3 : 40;
         den = (t == 0) ? 7 : 63;
         apply_reset(1, 1'b1, num, den);
         m_clear();
         for (int i = 0; i < 50; i++) begin
            do_step(y, v);
            e = m_step(1, num, den);
            chk(y == e, "R9 order1 dither", y, e);
         end
      end

      // R6: dither in orders 2 and 3.
      for (int ord = 2; ord <= 3; ord++) begin
         for (int t = 0; t < 2; t++) begin
            int num;
            num = (t == 0) ? 21 : 1;
            apply_reset(ord, 1'b1, num, 63);
            m_clear();
            s = 0; diffs = 0;
            for (int i = 0; i < 300; i++) begin
               do_step(y, v);
               e = m_step(ord, num, 63);
               if (y != e) diffs++;
               if (ord == 2) chk(y >= -1 && y <= 2, "R6 range order2", y, 2);
               else          chk(y >= -3 && y <= 4, "R6 range order3", y, 4);
               s += y;
            end
            chk(diffs > 0, "R6 dither alters sequence", diffs, 1);
            chk(mean_ok(s, 300, num, 63), "R6 R5 dithered mean", 63*s, 300*num);
         end
      end

      // R7: configuration change clears state and drops a coincident step.
      apply_reset(2, 1'b0, 5, 16);
      m_clear();
      for (int i = 0; i < 10; i++) begin
         do_step(y, v);
         e = m_step(2, 5, 16);
         chk(y == e, "R3", y, e);
      end
      @(negedge clk) begin order_i = 2'd3; step_i = 1'b1; end
      @(negedge clk) step_i = 1'b0;
      chk(valid_o == 1'b0, "R7 step dropped on order change", int'(valid_o), 0);
      chk(offset_o == 4'sd0, "R7 offset cleared", int'(offset_o), 0);
      @(negedge clk) order_i = 2'd2;
      @(negedge clk); @(negedge clk);
      m_clear();
      for (int i = 0; i < 20; i++) begin
         do_step(y, v);
         e = m_step(2, 5, 16);
         chk(y == e, "R7 restart after order change", y, e);
      end
      @(negedge clk) begin dither_en_i = 1'b1; step_i = 1'b1; end
      @(negedge clk) step_i = 1'b0;
      chk(valid_o == 1'b0, "R7 step dropped on dither change", int'(valid_o), 0);
      @(negedge clk) dither_en_i = 1'b0;
      @(negedge clk); @(negedge clk);
      m_clear();
      for (int i = 0; i < 20; i++) begin
         do_step(y, v);
         e = m_step(2, 5, 16);
         chk(y == e, "R7 restart after dither change", y, e);
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog R1 actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule